// File: doc/BRIEF.md
# Programmable-Priority Maskable Interrupt Controller

This block gathers a set of maskable interrupt request lines (55 by default) and hands at most one of them at a time to the CPU. Each line has a small control register that holds a mask bit and a 3-bit priority level. A rising edge on a line sets that line's pending flag. The flag stays set until the CPU accepts the request or software clears it. Masking a line only keeps it out of arbitration, so a masked request is still pending and is taken up by priority as soon as it is unmasked.

Selection works in two stages. First the best programmable level wins, with level 0 being the most urgent. Among requests at that level, the lowest source index wins. The winner is offered to the CPU only when the CPU's NP and ID status inputs are both clear. It must also be strictly more urgent than the level currently in service. The block keeps a record of the levels in service. Acceptance adds the winner's level to that record, and an end-of-service pulse removes the most urgent level in service. As a result, a request at the same level as the routine in progress never nests.

Top module: `intc_core`

## Requirements
- R1: After reset, no request is pending or offered, and every control register reads 0x0F (pending 0, masked, level 7).
- R2: A 0-to-1 transition on a request line sets its pending flag. A line that is held high does not set the flag again after acceptance.
- R3: A masked pending request is not offered and stays pending. It is offered once its mask bit is cleared.
- R4: Among offerable requests, the one with the numerically lowest level is offered.
- R5: Among offerable requests that share the best level, the lowest source index is offered.
- R6: While np_i or id_i is high, nothing is offered and pending flags are kept. The winner is offered once both inputs are low.
- R7: While any level is in service, a request is offered only if its level is strictly lower in value than the most urgent level in service.
- R8: A cycle with irq_valid_o and irq_ack_i both high clears the offered source's pending flag and marks its level in service. An eoi_i pulse removes the most urgent level in service.
- R9: irq_code_o equals CODE_BASE + 16 × irq_idx_o, with CODE_BASE defaulting to 0x0080, and irq_lvl_o equals the offered source's level.
- R10: Control register layout: bits [2:0] hold the level and bit 3 holds the mask (1 means masked). On a write, bit 4 set to 1 clears the pending flag. On a read, bit 4 returns the pending flag.
- R11: A request edge in the same cycle as a clear of the same source leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 55 | Interrupt request lines |
| reg_we_i | input | 1 | Control register write strobe |
| reg_addr_i | input | 6 | Control register select (source index) |
| reg_wdata_i | input | 5 | Write data: clear-pending, mask, level |
| reg_rdata_o | output | 5 | Read data: pending, mask, level |
| np_i | input | 1 | CPU NP status flag, blocks acceptance |
| id_i | input | 1 | CPU ID status flag, blocks acceptance |
| irq_valid_o | output | 1 | A request is offered |
| irq_idx_o | output | 6 | Offered source index |
| irq_lvl_o | output | 3 | Offered source level |
| irq_code_o | output | 16 | Offered exception code |
| irq_ack_i | input | 1 | CPU accepts the offered request |
| eoi_i | input | 1 | End of service, removes the most urgent in-service level |

## Verification
A corrupted in-service record shows up directly at the ports. A stuck level suppresses irq_valid_o for every request at that level or a less urgent one. A lost level lets a request at the same level appear in the very next cycle after acceptance. A wrong pending flag shows up on the combinational read path in the cycle after the event, and an arbitration error shows up as a wrong irq_idx_o in the first cycle a set of requests becomes offerable. The bench therefore samples one cycle after every stimulus.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned NLVL   = 1 << LVL_W;
  localparam int unsigned CODE_W = 16;

  typedef logic [LVL_W-1:0] lvl_t;

  // control register field positions
  localparam int unsigned F_MASK = LVL_W;
  localparam int unsigned F_PEND = LVL_W + 1;
  localparam int unsigned CTL_W  = LVL_W + 2;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = 55,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        req_i,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        addr_i,
  input  logic [CTL_W-1:0]        wdata_i,
  input  logic                    ack_i,
  input  logic [IDX_W-1:0]        ack_idx_i,
  output logic [CTL_W-1:0]        rdata_o,
  output logic [N_SRC-1:0]        pend_o,
  output logic [N_SRC-1:0]        mask_o,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl_o
);
  logic [N_SRC-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_i;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic sel, edge_s, clr;
    assign sel    = we_i && (addr_i == IDX_W'(i));
    assign edge_s = req_i[i] && !req_q[i];
    assign clr    = (sel && wdata_i[F_PEND]) || (ack_i && ack_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[i] <= 1'b0;
        mask_o[i] <= 1'b1;
        lvl_o[i]  <= '1;
      end else begin
        if (edge_s)   pend_o[i] <= 1'b1;   // new edge beats any clear
        else if (clr) pend_o[i] <= 1'b0;
        if (sel) begin
          mask_o[i] <= wdata_i[F_MASK];
          lvl_o[i]  <= wdata_i[LVL_W-1:0];
        end
      end
    end

    AST_EDGE_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[i] && !req_q[i]) |=> pend_o[i]); // R2
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (addr_i == IDX_W'(i)) rdata_o = {pend_o[i], mask_o[i], lvl_o[i]};
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = 55,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_SRC-1:0]            elig_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                        cand_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic [LVL_W-1:0]            lvl_o,
  output logic [N_SRC-1:0]            grant_o
);
  logic [NLVL-1:0] lvl_any;
  logic [N_SRC-1:0] at_best;

  // stage 1: best programmable level
  always_comb begin
    lvl_any = '0;
    for (int i = 0; i < N_SRC; i++)
      if (elig_i[i]) lvl_any[lvl_i[i]] = 1'b1;
    lvl_o = '0;
    for (int l = NLVL-1; l >= 0; l--)
      if (lvl_any[l]) lvl_o = LVL_W'(l);
    cand_o = |lvl_any;
  end

  // stage 2: fixed order, lowest index
  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      at_best[i] = elig_i[i] && (lvl_i[i] == lvl_o);
    idx_o   = '0;
    grant_o = '0;
    for (int i = N_SRC-1; i >= 0; i--)
      if (at_best[i]) idx_o = IDX_W'(i);
    if (cand_o) grant_o[idx_o] = 1'b1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && (cand_o == (|elig_i))); // R5
endmodule

// File: rtl/intc_isr_stack.sv
module intc_isr_stack
  import intc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [LVL_W:0]   cur_lvl_o   // NLVL when nothing in service
);
  logic [NLVL-1:0] busy_q, pop_mask, push_mask;

  always_comb begin
    cur_lvl_o = (LVL_W+1)'(NLVL);
    for (int l = NLVL-1; l >= 0; l--)
      if (busy_q[l]) cur_lvl_o = (LVL_W+1)'(l);
    pop_mask  = '0;
    if (pop_i && !cur_lvl_o[LVL_W]) pop_mask[cur_lvl_o[LVL_W-1:0]] = 1'b1;
    push_mask = '0;
    if (push_i) push_mask[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= (busy_q & ~pop_mask) | push_mask;

  AST_NO_SAME_LVL_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ({1'b0, push_lvl_i} < cur_lvl_o)); // R7
  AST_PUSH_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> busy_q[$past(push_lvl_i)]); // R8
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC     = 55,
  parameter logic [15:0] CODE_BASE = 16'h0080,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             reg_we_i,
  input  logic [IDX_W-1:0] reg_addr_i,
  input  logic [CTL_W-1:0] reg_wdata_i,
  output logic [CTL_W-1:0] reg_rdata_o,
  input  logic             np_i,
  input  logic             id_i,
  output logic             irq_valid_o,
  output logic [IDX_W-1:0] irq_idx_o,
  output logic [LVL_W-1:0] irq_lvl_o,
  output logic [15:0]      irq_code_o,
  input  logic             irq_ack_i,
  input  logic             eoi_i
);
  logic [N_SRC-1:0]            pend, mask, grant;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic                        cand, fire;
  logic [LVL_W:0]              cur_lvl;

  assign fire = irq_valid_o && irq_ack_i;

  intc_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i, .rst_ni, .req_i,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ack_i(fire), .ack_idx_i(irq_idx_o),
    .rdata_o(reg_rdata_o), .pend_o(pend), .mask_o(mask), .lvl_o(lvl)
  );

  intc_arbiter #(.N_SRC(N_SRC)) u_arb (
    .clk_i, .rst_ni, .elig_i(pend & ~mask), .lvl_i(lvl),
    .cand_o(cand), .idx_o(irq_idx_o), .lvl_o(irq_lvl_o), .grant_o(grant)
  );

  intc_isr_stack u_isr (
    .clk_i, .rst_ni, .push_i(fire), .push_lvl_i(irq_lvl_o),
    .pop_i(eoi_i), .cur_lvl_o(cur_lvl)
  );

  assign irq_valid_o = cand && !np_i && !id_i && ({1'b0, irq_lvl_o} < cur_lvl);
  assign irq_code_o  = CODE_BASE + (16'(irq_idx_o) << 4);

  AST_OFFER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (pend[irq_idx_o] && !mask[irq_idx_o] && grant[irq_idx_o])); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !(req_i[irq_idx_o])) |=> !pend[$past(irq_idx_o)]); // R8
endmodule

// File: tb/intc_core_bench.sv
module intc_core_bench;
  localparam int N = 55;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0;
  logic we = 0, np = 0, id = 0, ack = 0, eoi = 0;
  logic [5:0] addr = '0;
  logic [4:0] wdata = '0, rdata;
  logic valid;
  logic [5:0] idx;
  logic [2:0] lvl;
  logic [15:0] code;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  intc_core u_intc_core (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .np_i(np), .id_i(id),
    .irq_valid_o(valid), .irq_idx_o(idx), .irq_lvl_o(lvl), .irq_code_o(code),
    .irq_ack_i(ack), .eoi_i(eoi)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(int a, int d);
    addr = 6'(a); wdata = 5'(d); we = 1; cyc(); we = 0;
  endtask

  task automatic rd_pend(string tag, int a, int exp);
    addr = 6'(a); #1; chk(tag, rdata[4], exp);
  endtask

  task automatic pulse(int a);
    req[a] = 1; cyc(); req[a] = 0;
  endtask

  task automatic take(string tag, int exp_idx);
    chk(tag, valid, 1); chk(tag, idx, exp_idx);
    ack = 1; cyc(); ack = 0;
  endtask

  task automatic end_srv(); eoi = 1; cyc(); eoi = 0; endtask

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    // R1 reset state
    chk("R1 valid", valid, 0);
    for (int i = 0; i < N; i += 18) begin addr = 6'(i); #1; chk("R1 ctl", rdata, 5'h0F); end

    // R9 / R2 sweep over every source
    for (int i = 0; i < N; i++) begin
      wr(i, i % 8);
      pulse(i);
      chk("R2 valid", valid, 1);
      chk("R9 idx", idx, i);
      chk("R9 lvl", lvl, i % 8);
      chk("R9 code", code, 16'h0080 + 16 * i);
      take("R8 take", i);
      chk("R8 valid after ack", valid, 0);
      rd_pend("R8 pend cleared", i, 0);
      end_srv();
    end
    for (int i = 0; i < N; i++) wr(i, 5'h0F);

    // R3 masked stays pending, offered after unmask
    pulse(10); cyc();
    chk("R3 masked not offered", valid, 0);
    rd_pend("R3 still pending", 10, 1);
    wr(10, 5'h06);
    take("R3 offered after unmask", 10); end_srv();

    // R4 best level wins
    wr(20, 5); wr(40, 2);
    req[20] = 1; req[40] = 1; cyc(); req[20] = 0; req[40] = 0;
    take("R4 better level", 40); end_srv();
    take("R4 remaining", 20); end_srv();

    // R5 equal level, lower index
    wr(30, 3); wr(12, 3);
    req[30] = 1; req[12] = 1; cyc(); req[30] = 0; req[12] = 0;
    take("R5 lower index", 12); end_srv();
    take("R5 remaining", 30); end_srv();

    // R6 NP / ID block
    wr(5, 1);
    np = 1; pulse(5); cyc();
    chk("R6 np blocks", valid, 0); rd_pend("R6 np keeps pending", 5, 1);
    np = 0; id = 1; cyc();
    chk("R6 id blocks", valid, 0);
    id = 0; #1;
    take("R6 offered when clear", 5); end_srv();

    // R7 nesting strictly higher only
    wr(7, 4); wr(8, 4); wr(9, 3);
    pulse(7); take("R7 first", 7);
    pulse(8); chk("R7 same level blocked", valid, 0);
    pulse(9); take("R7 higher nests", 9);
    chk("R7 blocked under two levels", valid, 0);
    end_srv(); chk("R7 still blocked at level 4", valid, 0);
    end_srv(); take("R7 offered after pops", 8); end_srv();
    chk("R8 idle after all pops", valid, 0);

    // R2 held line does not re-trigger
    wr(3, 0); req[3] = 1; cyc();
    take("R2 held first", 3); cyc();
    chk("R2 held no retrigger", valid, 0);
    req[3] = 0; end_srv();

    // R10 software clear
    wr(44, 5'h0E); pulse(44); rd_pend("R10 pending set", 44, 1);
    wr(44, 5'h1E); rd_pend("R10 cleared by write", 44, 0);
    wr(44, 5'h06); chk("R10 nothing offered", valid, 0);
    addr = 6'd44; #1; chk("R10 readback", rdata, 5'h06);

    // R11 edge beats clear
    wr(50, 5'h0A);
    addr = 6'd50; wdata = 5'h1A; we = 1; req[50] = 1; cyc(); we = 0; req[50] = 0;
    rd_pend("R11 edge wins over clear", 50, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule